// File: doc/BRIEF.md
# Sequential Turn Signal Lamp Controller

This block drives six rear signal lamps, three on each side of the vehicle, from three switch inputs: left turn, right turn and hazard. On a single turn switch, the lamps on that side light up as a sweep that grows outward from the lamp nearest the centre. The sweep adds one lamp per step until the whole side is lit, then goes dark for one step and starts again. In hazard mode, and also when both turn switches are on together, all six lamps blink together: on for one step, off for the next.

The block contains a free-running divider that turns the system clock into a one-cycle step pulse at a visible rate. The state machine and its registered lamp outputs change only on that pulse. It uses a minimal state set: one dark state, one state per sweep length on each side, and one all-lit state. The switch inputs are taken as already debounced and synchronous. The number of lamps per side is a parameter, three by default.

Top module: `turn_lamp_ctrl`

## Requirements
- R1: A synchronous active-low reset turns every lamp off and clears the divider. With hazard on from the release of reset, the lamps first light at exactly the DIV-th rising edge after release, where DIV = CLK_HZ / STEP_HZ.
- R2: Lamp outputs change only at every DIV-th rising edge (a step). Between steps they hold their value.
- R3: With only the left switch on, the left lamps repeat the cycle dark, 1, 2, 3 lamps lit, one stage per step. `lamps_left` bit 0 is the innermost lamp and bit 2 the outermost, so the values are 000, 001, 011, 111.
- R4: With only the right switch on, the right lamps follow the same cycle. `lamps_right` bit 0 is the innermost lamp.
- R5: With hazard on, all six lamps alternate together between all lit and all dark, one phase per step.
- R6: Hazard takes priority over either turn switch or both, and gives exactly the R5 behaviour.
- R7: Left and right on together, with hazard off, behaves exactly as hazard mode.
- R8: When the selected mode changes while a sweep or a lit hazard phase is shown, the next step turns all lamps off. The new mode's sequence then begins at the following step.
- R9: With no switch on, the next step turns all lamps off and they stay off.
- R10: During a single-side sweep the lamps on the opposite side stay dark. Whenever both sides show light, all six are lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_left | input | 1 | Left turn switch |
| sw_right | input | 1 | Right turn switch |
| sw_hazard | input | 1 | Hazard switch |
| lamps_left | output | LAMPS_PER_SIDE | Left lamps, bit 0 innermost, 1 = lit |
| lamps_right | output | LAMPS_PER_SIDE | Right lamps, bit 0 innermost, 1 = lit |

## Verification
The hardest situation to reach is a mode change that lands at each point of each running sequence. Examples are a right request arriving while the left sweep is at two lamps, or a single turn arriving while the hazard lamps are lit. Only then does the forced dark step of R8 show. The bench reaches every such case with a small divider. It resets, holds a first switch pattern for one to four steps, then switches to a second pattern for five more steps. It does this for every ordered pair of the eight switch patterns, and it compares the lamps every cycle against a step model kept in the bench.

// File: rtl/turn_lamp_pkg.sv
// Package: shared encodings for the turn lamp controller.
// Assumes: consumers import it; no state lives here.
package turn_lamp_pkg;

    // Mode selected by the switch decoder, priority already resolved.
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_LEFT  = 2'd1,
        MODE_RIGHT = 2'd2,
        MODE_FLASH = 2'd3
    } lamp_mode_e;

    // Phase of the sequencer; the sweep length is kept beside it.
    typedef enum logic [1:0] {
        PH_DARK  = 2'd0,
        PH_LEFT  = 2'd1,
        PH_RIGHT = 2'd2,
        PH_LIT   = 2'd3
    } seq_phase_e;

endpackage

// File: rtl/lamp_step_divider.sv
// Module: lamp_step_divider
// Emits a one-cycle step pulse every DIV_CYCLES system clocks.
// Assumes: DIV_CYCLES >= 1; the counter restarts from zero on reset.
module lamp_step_divider #(
    parameter int DIV_CYCLES = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic step
);
    localparam int CW = (DIV_CYCLES > 1) ? $clog2(DIV_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_CYCLES - 1);

    logic [CW-1:0] count_q;

    // Free-running modulo-DIV_CYCLES counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (count_q == LAST)
            count_q <= '0;
        else
            count_q <= count_q + CW'(1);
    end

    // Pulse on the last count of each period.
    always_comb step = (count_q == LAST);

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LAST);

    generate
        if (DIV_CYCLES > 1) begin : g_pulse_check
            assert_step_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
                step |=> !step);
        end
    endgenerate
endmodule

// File: rtl/lamp_mode_decode.sv
// Module: lamp_mode_decode
// Resolves the three switches into one mode: hazard first, then both
// turns together as hazard, then a single turn, else off.
// Assumes: switches are already debounced and synchronous.
module lamp_mode_decode
    import turn_lamp_pkg::*;
(
    input  logic       sw_left,
    input  logic       sw_right,
    input  logic       sw_hazard,
    output lamp_mode_e mode
);
    // Priority resolution of the switch inputs.
    always_comb begin
        if (sw_hazard || (sw_left && sw_right))
            mode = MODE_FLASH;
        else if (sw_left)
            mode = MODE_LEFT;
        else if (sw_right)
            mode = MODE_RIGHT;
        else
            mode = MODE_OFF;
    end
endmodule

// File: rtl/lamp_sequencer.sv
// Module: lamp_sequencer
// Holds the phase and sweep length and works out the next state on
// each step. Any mode mismatch or end of a cycle returns to dark.
// Assumes: step is a one-cycle pulse; LAMPS_PER_SIDE >= 1.
module lamp_sequencer
    import turn_lamp_pkg::*;
#(
    parameter int LAMPS_PER_SIDE = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  lamp_mode_e           mode,
    output seq_phase_e           next_phase,
    output logic [$clog2(LAMPS_PER_SIDE+1)-1:0] next_len
);
    localparam int LW = $clog2(LAMPS_PER_SIDE + 1);
    localparam logic [LW-1:0] FULL = LW'(LAMPS_PER_SIDE);

    seq_phase_e    phase_q;
    logic [LW-1:0] len_q;

    // Next-state selection from the current state and resolved mode.
    always_comb begin
        next_phase = PH_DARK;
        next_len   = '0;
        unique case (phase_q)
            PH_DARK: begin
                unique case (mode)
                    MODE_FLASH: next_phase = PH_LIT;
                    MODE_LEFT:  begin next_phase = PH_LEFT;  next_len = LW'(1); end
                    MODE_RIGHT: begin next_phase = PH_RIGHT; next_len = LW'(1); end
                    default:    next_phase = PH_DARK;
                endcase
            end
            PH_LEFT: begin
                if (mode == MODE_LEFT && len_q < FULL) begin
                    next_phase = PH_LEFT;
                    next_len   = len_q + LW'(1);
                end
            end
            PH_RIGHT: begin
                if (mode == MODE_RIGHT && len_q < FULL) begin
                    next_phase = PH_RIGHT;
                    next_len   = len_q + LW'(1);
                end
            end
            default: next_phase = PH_DARK;
        endcase
    end

    // State register, loaded only on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_DARK;
            len_q   <= '0;
        end else if (step) begin
            phase_q <= next_phase;
            len_q   <= next_len;
        end
    end

    assert_hold_between_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(phase_q) && $stable(len_q)));

    assert_len_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_LEFT || phase_q == PH_RIGHT) ? (len_q >= LW'(1) && len_q <= FULL)
                                                      : (len_q == '0)));

    assert_mode_switch_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && phase_q == PH_LEFT && mode == MODE_RIGHT) |=> phase_q == PH_DARK);
endmodule

// File: rtl/lamp_output_drive.sv
// Module: lamp_output_drive
// Registers the lamp bits for the state being entered, so the lamps
// track the sequencer state with no extra delay.
// Assumes: next_phase/next_len are valid whenever step is high.
module lamp_output_drive
    import turn_lamp_pkg::*;
#(
    parameter int LAMPS_PER_SIDE = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step,
    input  seq_phase_e                next_phase,
    input  logic [$clog2(LAMPS_PER_SIDE+1)-1:0] next_len,
    output logic [LAMPS_PER_SIDE-1:0] lamps_left,
    output logic [LAMPS_PER_SIDE-1:0] lamps_right
);
    localparam int LW = $clog2(LAMPS_PER_SIDE + 1);

    logic [LAMPS_PER_SIDE-1:0] bar;
    logic [LAMPS_PER_SIDE-1:0] left_d;
    logic [LAMPS_PER_SIDE-1:0] right_d;

    // Thermometer bar: lamp i is lit when the sweep covers it.
    generate
        for (genvar i = 0; i < LAMPS_PER_SIDE; i++) begin : g_bar
            assign bar[i] = (next_len > LW'(i));
        end
    endgenerate

    // Per-side lamp pattern for the next phase.
    always_comb begin
        left_d  = '0;
        right_d = '0;
        unique case (next_phase)
            PH_LEFT:  left_d  = bar;
            PH_RIGHT: right_d = bar;
            PH_LIT:   begin left_d = '1; right_d = '1; end
            default:  ;
        endcase
    end

    // Output registers, loaded on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lamps_left  <= '0;
            lamps_right <= '0;
        end else if (step) begin
            lamps_left  <= left_d;
            lamps_right <= right_d;
        end
    end

    assert_lamps_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(lamps_left) && $stable(lamps_right)));

    assert_sweep_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (((lamps_left + 1'b1) & lamps_left) == '0) && (((lamps_right + 1'b1) & lamps_right) == '0));

    assert_opposite_dark_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lamps_left != '0 && lamps_right != '0) |-> (&lamps_left && &lamps_right));
endmodule

// File: rtl/turn_lamp_ctrl.sv
// Module: turn_lamp_ctrl (top)
// Sequential turn signal lamp controller: divider, switch decoder,
// sequencer and registered lamp outputs.
// Assumes: CLK_HZ is a multiple of STEP_HZ; switches are synchronous.
module turn_lamp_ctrl
    import turn_lamp_pkg::*;
#(
    parameter int CLK_HZ         = 50_000_000,
    parameter int STEP_HZ        = 4,
    parameter int LAMPS_PER_SIDE = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sw_left,
    input  logic                      sw_right,
    input  logic                      sw_hazard,
    output logic [LAMPS_PER_SIDE-1:0] lamps_left,
    output logic [LAMPS_PER_SIDE-1:0] lamps_right
);
    localparam int DIV_CYCLES = CLK_HZ / STEP_HZ;
    localparam int LW         = $clog2(LAMPS_PER_SIDE + 1);

    logic          step;
    lamp_mode_e    mode;
    seq_phase_e    next_phase;
    logic [LW-1:0] next_len;

    lamp_step_divider #(.DIV_CYCLES(DIV_CYCLES)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step)
    );

    lamp_mode_decode dec_i (
        .sw_left   (sw_left),
        .sw_right  (sw_right),
        .sw_hazard (sw_hazard),
        .mode      (mode)
    );

    lamp_sequencer #(.LAMPS_PER_SIDE(LAMPS_PER_SIDE)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .mode       (mode),
        .next_phase (next_phase),
        .next_len   (next_len)
    );

    lamp_output_drive #(.LAMPS_PER_SIDE(LAMPS_PER_SIDE)) drv_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .next_phase  (next_phase),
        .next_len    (next_len),
        .lamps_left  (lamps_left),
        .lamps_right (lamps_right)
    );

    assert_hazard_flash_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sw_hazard && lamps_left == '0 && lamps_right == '0) |=> (&lamps_left && &lamps_right));

    assert_hazard_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sw_hazard) |=> (lamps_left == lamps_right));

    assert_both_turns_flash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sw_left && sw_right) |=> (lamps_left == lamps_right));

    assert_idle_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !sw_left && !sw_right && !sw_hazard) |=> (lamps_left == '0 && lamps_right == '0));
endmodule

// File: tb/turn_lamp_ctrl_tb_top.sv
// Bench: sweeps every ordered pair of switch patterns with a small
// divider and compares lamps every cycle to a step model.
module turn_lamp_ctrl_tb_top;
    localparam int CLK_HZ  = 16;
    localparam int STEP_HZ = 4;
    localparam int NDIV    = CLK_HZ / STEP_HZ;
    localparam int NL      = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_left = 1'b0, sw_right = 1'b0, sw_hazard = 1'b0;
    logic [NL-1:0] lamps_left, lamps_right;

    int checks = 0;
    int fails  = 0;
    bit compare_on = 1'b0;

    // Model state: phase 0 dark, 1 left, 2 right, 3 all lit.
    int m_cnt = 0, m_phase = 0, m_len = 0;

    always #2 clk = ~clk;  // 250 MHz

    turn_lamp_ctrl #(.CLK_HZ(CLK_HZ), .STEP_HZ(STEP_HZ), .LAMPS_PER_SIDE(NL)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_left(sw_left), .sw_right(sw_right),
        .sw_hazard(sw_hazard), .lamps_left(lamps_left), .lamps_right(lamps_right)
    );

    // Step model from the requirements.
    always @(posedge clk) begin
        int md;
        if (!rst_n) begin
            m_cnt = 0; m_phase = 0; m_len = 0;
        end else begin
            if (m_cnt == NDIV - 1) begin
                md = (sw_hazard || (sw_left && sw_right)) ? 3 : sw_left ? 1 : sw_right ? 2 : 0;
                if (m_phase == 0) begin
                    m_phase = md; m_len = (md == 1 || md == 2) ? 1 : 0;
                end else if ((m_phase == 1 || m_phase == 2) && md == m_phase && m_len < NL) begin
                    m_len = m_len + 1;
                end else begin
                    m_phase = 0; m_len = 0;
                end
            end
            m_cnt = (m_cnt + 1) % NDIV;
        end
    end

    function automatic logic [NL-1:0] exp_side(int side);
        if (m_phase == 3) return '1;
        if (m_phase == side) return NL'((1 << m_len) - 1);
        return '0;
    endfunction

    function automatic string req_tag();
        if (!rst_n) return "R1";
        if (sw_hazard && (sw_left || sw_right)) return "R6";
        if (sw_hazard) return "R5";
        if (sw_left && sw_right) return "R7";
        if (m_phase == 1) return "R3 R10";
        if (m_phase == 2) return "R4 R10";
        if (m_phase == 3) return "R8";
        if (sw_left || sw_right) return "R8";
        return "R9";
    endfunction

    task automatic check(string tag, logic [NL-1:0] al, logic [NL-1:0] ar,
                         logic [NL-1:0] el, logic [NL-1:0] er);
        checks++;
        if (al !== el || ar !== er) begin
            fails++;
            $display("FAIL %s: lamps L=%b R=%b expected L=%b R=%b at %0t", tag, al, ar, el, er, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (compare_on)
            check(req_tag(), lamps_left, lamps_right, exp_side(1), exp_side(2));
    end

    task automatic set_sw(int pat);
        sw_left   = pat[0];
        sw_right  = pat[1];
        sw_hazard = pat[2];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(4 * 150_000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int edges;
        // R1: reset state with inputs active.
        set_sw(3'b111);
        repeat (3) @(negedge clk);
        check("R1", lamps_left, lamps_right, '0, '0);

        // R1 R2: first light lands exactly NDIV edges after release.
        set_sw(3'b100);
        rst_n = 1'b1;
        edges = 0;
        while (lamps_left == '0 && edges < 4 * NDIV) begin
            @(negedge clk);
            edges++;
        end
        checks++;
        if (edges != NDIV) begin
            fails++;
            $display("FAIL R1 R2: first lamp edge actual %0d expected %0d", edges, NDIV);
        end
        check("R5", lamps_left, lamps_right, '1, '1);

        // Exhaustive pair sweep: R2 through R10.
        compare_on = 1'b1;
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                for (int k = 1; k <= 4; k++) begin
                    set_sw(0);
                    do_reset();
                    set_sw(a);
                    repeat (k * NDIV) @(negedge clk);
                    set_sw(b);
                    repeat (5 * NDIV) @(negedge clk);
                end
            end
        end

        // R3: long left run, then R9 hold off.
        set_sw(0);
        do_reset();
        set_sw(3'b001);
        repeat (13 * NDIV) @(negedge clk);
        set_sw(0);
        repeat (6 * NDIV) @(negedge clk);
        check("R9", lamps_left, lamps_right, '0, '0);
        compare_on = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule